// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block decides, cycle by cycle, whether the decoded instruction at the head of a small pipeline may start on one of three functional units. Instructions are offered one at a time in program order. An offered instruction either issues in the same cycle or is held: it stays on the inputs and stalls, and nothing behind it can overtake it. The block only issues in order. Units finish in whatever order their latencies dictate, and each unit reports its own completion with a strobe.

The block tracks two things. One bit per architectural register marks a result that is still being computed. Each unit has a busy flag and the destination register it will write. An instruction is held if its unit is busy (structural), if either source names a pending register (read after write), or if its destination is already pending (write after write). A completion strobe in the same cycle frees the unit and its register for that cycle's decision, so an instruction that waits on that completion issues without losing a cycle. The new pending and busy marks made by that issue take priority over the clear.

Top module: `sb_issue_scoreboard`

## Requirements
- R1: In the first cycle after reset, a valid instruction with a legal unit code issues whatever its registers are.
- R2: When `in_valid` is 0, `issue` and `stall` are both 0. When it is 1, exactly one of them is 1.
- R3: When `issue` is 1, `issue_sel` is one-hot: bit k is set for unit code k (0, 1 or 2). Otherwise `issue_sel` is 0.
- R4: After an issue to unit k, no later instruction issues to unit k until `done[k]` is seen. It may issue in the same cycle as that strobe.
- R5: An instruction whose source (`in_src_a` or `in_src_b`) names the destination of an issued, not yet completed instruction stalls.
- R6: An instruction whose destination names the destination of an issued, not yet completed instruction stalls.
- R7: Completions may come in any order. Completion of a younger instruction releases its unit and register while an older one is still outstanding.
- R8: When a completion and a dependent issue touch the same unit and register in one cycle, the issue proceeds, and the register and unit are again marked outstanding afterwards.
- R9: Unit code 3 names no unit. Such an instruction never issues and raises `stall`.
- R10: A `done` strobe for a unit that is not busy changes no pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_unit | input | 2 | Functional unit code (0..2 legal) |
| in_dst | input | 3 | Destination register |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| done | input | 3 | Per-unit completion strobes |
| issue | output | 1 | Offered instruction issues this cycle |
| issue_sel | output | 3 | One-hot selected unit when issuing |
| stall | output | 1 | Offered instruction is held |

## Verification
The bound checker watches, on every cycle, that issue and stall are exclusive and follow `in_valid`, that the unit select is one-hot and matches the issue strobe, and that an illegal unit code never issues. It also checks that the next issue after an issue never reuses that unit, writes its destination, or reads it, unless the matching completion strobe arrives in that cycle. Longer waits, out-of-order release, ignored strobes on idle units and the state left after a same-cycle bypass can only be shown by the bench's directed sequences and its long pseudo-random sweep against an arithmetic model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int NUM_REGS  = 8;
  parameter int NUM_UNITS = 3;
  parameter int UNIT_W    = 2;
  localparam int REG_W    = $clog2(NUM_REGS);
endpackage

// File: rtl/sb_unit_tracker.sv
// Per-unit busy flag and destination tag; completion frees a unit for the
// decision made in the same cycle.
module sb_unit_tracker #(
  parameter int NU = 3,
  parameter int RW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NU-1:0]  done,
  input  logic [NU-1:0]  alloc,
  input  logic [RW-1:0]  alloc_dst,
  output logic [NU-1:0]  busy_eff,
  output logic [NU-1:0]  retire,
  output logic [NU*RW-1:0] retire_dst
);
  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic          busy_q;
    logic [RW-1:0] dst_q;

    assign retire[u]              = busy_q & done[u];
    assign busy_eff[u]            = busy_q & ~done[u];
    assign retire_dst[u*RW +: RW] = dst_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q <= 1'b0;
        dst_q  <= '0;
      end else if (alloc[u]) begin
        busy_q <= 1'b1;
        dst_q  <= alloc_dst;
      end else if (done[u]) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sb_pending_table.sv
// One outstanding-write bit per register. Set at issue, cleared by the
// retiring unit's tag; a set in the same cycle overrides the clear.
module sb_pending_table #(
  parameter int NR = 8,
  parameter int NU = 3,
  parameter int RW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NU-1:0]    retire,
  input  logic [NU*RW-1:0] retire_dst,
  input  logic             set_en,
  input  logic [RW-1:0]    set_dst,
  output logic [NR-1:0]    pend_eff
);
  logic [NR-1:0] pend_q;
  logic [NR-1:0] clr;
  logic [NR-1:0] set_vec;

  always_comb begin
    clr     = '0;
    set_vec = '0;
    for (int r = 0; r < NR; r++) begin
      for (int u = 0; u < NU; u++) begin
        if (retire[u] && retire_dst[u*RW +: RW] == RW'(r)) clr[r] = 1'b1;
      end
      if (set_en && set_dst == RW'(r)) set_vec[r] = 1'b1;
    end
  end

  assign pend_eff = pend_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_eff | set_vec;
  end
endmodule

// File: rtl/sb_hazard_check.sv
// Combinational issue decision for the offered instruction.
module sb_hazard_check #(
  parameter int NR = 8,
  parameter int NU = 3,
  parameter int RW = 3,
  parameter int UW = 2
) (
  input  logic          in_valid,
  input  logic [UW-1:0] in_unit,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src_a,
  input  logic [RW-1:0] in_src_b,
  input  logic [NR-1:0] pend_eff,
  input  logic [NU-1:0] busy_eff,
  output logic          issue,
  output logic          stall,
  output logic [NU-1:0] sel
);
  logic [NU-1:0] unit_dec;
  logic          unit_ok;
  logic          struct_hz;
  logic          raw_hz;
  logic          waw_hz;
  logic          hazard;

  always_comb begin
    unit_dec = '0;
    for (int u = 0; u < NU; u++) begin
      if (in_unit == UW'(u)) unit_dec[u] = 1'b1;
    end
  end

  assign unit_ok   = |unit_dec;
  assign struct_hz = |(unit_dec & busy_eff);
  assign raw_hz    = pend_eff[in_src_a] | pend_eff[in_src_b];
  assign waw_hz    = pend_eff[in_dst];
  assign hazard    = ~unit_ok | struct_hz | raw_hz | waw_hz;

  assign issue = in_valid & ~hazard;
  assign stall = in_valid & hazard;
  assign sel   = issue ? unit_dec : '0;
endmodule

// File: rtl/sb_issue_scoreboard.sv
module sb_issue_scoreboard #(
  parameter int NUM_REGS  = sb_pkg::NUM_REGS,
  parameter int NUM_UNITS = sb_pkg::NUM_UNITS,
  parameter int UNIT_W    = sb_pkg::UNIT_W,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [UNIT_W-1:0]    in_unit,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src_a,
  input  logic [REG_W-1:0]     in_src_b,
  input  logic [NUM_UNITS-1:0] done,
  output logic                 issue,
  output logic [NUM_UNITS-1:0] issue_sel,
  output logic                 stall
);
  logic [NUM_UNITS-1:0]       busy_eff;
  logic [NUM_UNITS-1:0]       retire;
  logic [NUM_UNITS*REG_W-1:0] retire_dst;
  logic [NUM_REGS-1:0]        pend_eff;

  sb_unit_tracker #(.NU(NUM_UNITS), .RW(REG_W)) units_i (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .alloc      (issue_sel),
    .alloc_dst  (in_dst),
    .busy_eff   (busy_eff),
    .retire     (retire),
    .retire_dst (retire_dst)
  );

  sb_pending_table #(.NR(NUM_REGS), .NU(NUM_UNITS), .RW(REG_W)) pend_i (
    .clk        (clk),
    .rst        (rst),
    .retire     (retire),
    .retire_dst (retire_dst),
    .set_en     (issue),
    .set_dst    (in_dst),
    .pend_eff   (pend_eff)
  );

  sb_hazard_check #(.NR(NUM_REGS), .NU(NUM_UNITS), .RW(REG_W), .UW(UNIT_W)) hz_i (
    .in_valid (in_valid),
    .in_unit  (in_unit),
    .in_dst   (in_dst),
    .in_src_a (in_src_a),
    .in_src_b (in_src_b),
    .pend_eff (pend_eff),
    .busy_eff (busy_eff),
    .issue    (issue),
    .stall    (stall),
    .sel      (issue_sel)
  );
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int NUM_REGS  = 8,
  parameter int NUM_UNITS = 3,
  parameter int UNIT_W    = 2,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [UNIT_W-1:0]    in_unit,
  input logic [REG_W-1:0]     in_dst,
  input logic [REG_W-1:0]     in_src_a,
  input logic [REG_W-1:0]     in_src_b,
  input logic [NUM_UNITS-1:0] done,
  input logic                 issue,
  input logic [NUM_UNITS-1:0] issue_sel,
  input logic                 stall
);
  // R1
  first_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && in_valid && in_unit < UNIT_W'(NUM_UNITS)) |-> issue);

  // R2
  issue_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(issue && stall));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!issue && !stall));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_sel) && (issue == (issue_sel != '0)));

  // R9
  bad_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_unit >= UNIT_W'(NUM_UNITS)) |-> (stall && !issue));

  // R6
  back_waw_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> !(issue && in_dst == $past(in_dst) && !(|(done & $past(issue_sel)))));

  // R5
  back_raw_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> !(issue && (in_src_a == $past(in_dst) || in_src_b == $past(in_dst))
                && !(|(done & $past(issue_sel)))));

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit_chk
    // R4
    unit_reuse_chk: assert property (@(posedge clk) disable iff (rst)
      (issue && issue_sel[k]) |=> !(issue_sel[k] && !done[k]));
  end
endmodule

bind sb_issue_scoreboard sb_scoreboard_chk #(
  .NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)
) chk_i (.*);

// File: tb/sb_issue_scoreboard_tb.sv
`timescale 1ns/1ps
module sb_issue_scoreboard_tb_top;
  localparam int NR = 8;
  localparam int NU = 3;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [1:0]    in_unit;
  logic [RW-1:0] in_dst, in_src_a, in_src_b;
  logic [NU-1:0] done;
  logic          issue, stall;
  logic [NU-1:0] issue_sel;

  always #2.5 clk = ~clk;

  sb_issue_scoreboard dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .done(done), .issue(issue), .issue_sel(issue_sel), .stall(stall)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // reference state
  logic [NR-1:0] m_pend;
  logic [NU-1:0] m_busy;
  logic [RW-1:0] m_dst [NU];

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // exp_issue < 0 means only the model decides
  task automatic step(input bit v, input int u, input int d, input int a, input int b,
                      input int dn, input string tag, input int exp_issue);
    logic [NU-1:0] ret;
    logic [NR-1:0] clr, pe;
    logic [NU-1:0] be, sel_e;
    bit hz, iss;
    @(negedge clk);
    in_valid = v; in_unit = 2'(u); in_dst = RW'(d);
    in_src_a = RW'(a); in_src_b = RW'(b); done = NU'(dn);
    #1;
    ret = done & m_busy;
    clr = '0;
    for (int k = 0; k < NU; k++) if (ret[k]) clr[m_dst[k]] = 1'b1;
    pe = m_pend & ~clr;
    be = m_busy & ~done;
    hz = (u > 2) || (u <= 2 && be[u]) || pe[a] || pe[b] || pe[d];
    iss = v && !hz;
    sel_e = '0;
    if (iss) sel_e[u] = 1'b1;
    check1(tag, "issue", int'(issue), int'(iss));
    check1(tag, "stall", int'(stall), int'(v && hz));
    check1(tag, "issue_sel", int'(issue_sel), int'(sel_e));
    if (exp_issue >= 0) check1(tag, "issue (directed)", int'(issue), exp_issue);
    m_pend = pe;
    m_busy = m_busy & ~done;
    if (iss) begin
      m_pend[d] = 1'b1;
      m_busy[u] = 1'b1;
      m_dst[u]  = RW'(d);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; in_valid = 0; in_unit = 0; in_dst = 0;
    in_src_a = 0; in_src_b = 0; done = 0;
    m_pend = '0; m_busy = '0;
    for (int k = 0; k < NU; k++) m_dst[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    step(0, 0, 0, 0, 0, 0, "R2", 0);
    step(1, 0, 1, 2, 3, 0, "R1", 1);   // r1 pending, unit0 busy
    step(1, 0, 4, 5, 6, 0, "R4", 0);   // unit0 busy
    step(1, 1, 5, 1, 0, 0, "R5", 0);   // reads r1
    step(1, 2, 1, 0, 0, 0, "R6", 0);   // writes r1
    step(1, 3, 7, 0, 0, 0, "R9", 0);   // no such unit
    step(1, 2, 1, 0, 0, 2, "R10", 0);  // strobe on idle unit1
    step(1, 0, 1, 1, 1, 1, "R8", 1);   // bypass on unit0 / r1
    step(1, 1, 6, 1, 0, 0, "R8", 0);   // r1 pending again
    step(1, 1, 2, 0, 0, 0, "R3", 1);   // sel = unit1
    step(1, 2, 3, 0, 0, 0, "R3", 1);   // sel = unit2
    step(0, 0, 0, 0, 0, 4, "R7", 0);   // unit2 completes first
    step(1, 2, 0, 3, 4, 0, "R7", 1);   // r3 and unit2 released
    step(1, 0, 7, 2, 0, 0, "R7", 0);   // unit0 busy, r2 still outstanding
    step(0, 0, 0, 0, 0, 7, "R2", 0);   // drain

    lfsr = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      int u, d, a, b, dn;
      for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      u  = int'(lfsr[1:0]);
      d  = int'(lfsr[4:2]);
      a  = int'(lfsr[7:5]);
      b  = int'(lfsr[10:8]);
      dn = int'(lfsr[13:11]) & int'(lfsr[15:13]);
      step(lfsr[14] | lfsr[3], u, d, a, b, dn, "R4 R5 R6 R7 R8 R10 sweep", -1);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule